// File: doc/BRIEF.md
# Serial Port Status and Interrupt Register Block

This block holds the control, FIFO-control, status and overrun state of a FIFO-based serial port. It turns that state into four level interrupt requests: transmit, receive, receive-error and break. The transmit and receive FIFOs stay outside the block. They report their live fill counts, and the block hands back the fill thresholds it decodes, single-cycle FIFO clear pulses and the per-frame routing decisions. On each frame tick those decisions say whether to pop a transmit byte, whether it leaves on the line or loops back into the receive queue, and whether a byte from the line is accepted.

Software writes a status flag to 0 to clear it. A flag whose live condition still holds springs back to 1 in the same write. The overrun flag has its own register and only software can clear it. While it is set, reception stops.

Top module: `sio_status_block`

## Requirements
- R1: After reset the status register reads 0x60 (transmit-end and transmit-empty set), the control register, the FIFO control register and the overrun flag are 0, and all four interrupt lines are low.
- R2: Status bits are: 7 receive error, 6 transmit end, 5 transmit empty, 4 break, 3 framing error, 2 parity error, 1 receive full, 0 data ready. A status write (reg_sel 2) stores old AND written data. Transmit end is then forced to 1 if tx_count is non-zero, transmit empty if tx_count <= tx_thr, and receive full if rx_count >= rx_thr.
- R3: FIFO control (reg_sel 1) bits 7:6 choose the receive threshold, with codes 0..3 giving 1, 4, 8, 14. Bits 5:4 choose the transmit threshold, with codes 0..3 giving 8, 4, 2, 1. Bit 3 is stored. Bits 2 and 1 always read back 0. Bit 0 is loopback.
- R4: Writing FIFO control with bit 2 set pulses tx_fifo_clr in the write cycle and sets transmit end and transmit empty. Writing it with bit 1 set pulses rx_fifo_clr and clears data ready and receive full.
- R5: On a frame tick with transmit enabled (control bit 5) and tx_count non-zero, tx_pop is high. Afterwards transmit empty is set if tx_count-1 <= tx_thr, and transmit end is set if tx_count was 1.
- R6: With loopback on, a popped byte asserts loop_push (if reception is accepted) and never line_tx_valid, and line_rx_pop stays low. With loopback off, a popped byte asserts line_tx_valid, and line_rx_pop follows frame_tick, line_rx_avail and acceptance.
- R7: Reception is accepted only while control bit 4 is set and the overrun flag is clear.
- R8: A receive push sets receive full if rx_count+1 >= rx_thr. If rx_count equals the depth the byte is dropped and the overrun flag is set instead. A line byte pushed with rx_frame_err sets bits 7 and 3, and one with rx_parity_err sets bits 7 and 2.
- R9: Data ready is set on a frame tick with no push in this tick or the previous tick, when 0 < rx_count < rx_thr.
- R10: A brk_det pulse sets status bit 4.
- R11: The overrun flag is cleared only by writing 0 to bit 0 of the line register (reg_sel 3). Writing 1 never sets it.
- R12: irq_tx is control bit 7 AND transmit empty. irq_rx is control bit 6 AND (data ready OR receive full). irq_err is (bit 6 OR bit 3) AND (receive error OR overrun). irq_brk is (bit 6 OR bit 3) AND break. Each line is a level that falls in the cycle after its enable or its flag goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 FIFO control, 2 status, 3 line/overrun |
| reg_wdata | input | 8 | Write data |
| tx_count | input | CNT_W | Live transmit FIFO fill |
| rx_count | input | CNT_W | Live receive FIFO fill |
| frame_tick | input | 1 | One pulse per serial frame time |
| line_rx_avail | input | 1 | A byte from the line is waiting |
| rx_frame_err | input | 1 | Waiting line byte has a framing error |
| rx_parity_err | input | 1 | Waiting line byte has a parity error |
| brk_det | input | 1 | Break condition detected |
| ctrl_q | output | 8 | Control register readback |
| fcr_q | output | 8 | FIFO control readback |
| status_q | output | 8 | Status flags |
| overrun_q | output | 1 | Overrun flag |
| rx_thr | output | CNT_W | Decoded receive threshold |
| tx_thr | output | CNT_W | Decoded transmit threshold |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_pop | output | 1 | Pop one transmit byte |
| line_tx_valid | output | 1 | Popped byte goes to the line |
| loop_push | output | 1 | Popped byte goes into the receive FIFO |
| line_rx_pop | output | 1 | Take the line byte into the receive FIFO |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break interrupt |

## Verification
The bench tries to clear flags whose condition is still live. A design that cleared unconditionally would leave transmit end or receive full at 0 while data is still queued, and would lose the interrupt for it. It tries to clear overrun by writing 1, expects data ready only on the second idle tick after a push, and pushes into a full receive FIFO, where a wrong design would raise receive full or the error flags instead of overrun. It also turns off interrupt enables while the flags stay set, to catch lines that latch instead of following the enables. In loopback it checks that a popped byte never also appears on the line.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FCR  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_LINE = 2'd3
  } sio_sel_e;

  // status bit positions
  localparam int ST_DR   = 0;
  localparam int ST_RDF  = 1;
  localparam int ST_PER  = 2;
  localparam int ST_FER  = 3;
  localparam int ST_BRK  = 4;
  localparam int ST_TDFE = 5;
  localparam int ST_TEND = 6;
  localparam int ST_ER   = 7;

  // control bit positions
  localparam int CT_TIE  = 7;
  localparam int CT_RIE  = 6;
  localparam int CT_TE   = 5;
  localparam int CT_RE   = 4;
  localparam int CT_REIE = 3;

  // FIFO control bit positions
  localparam int FC_TRST = 2;
  localparam int FC_RRST = 1;
  localparam int FC_LOOP = 0;

  localparam logic [7:0] STATUS_RESET = 8'h60;

  function automatic int clamp_depth(input int v, input int depth);
    return (v > depth) ? depth : v;
  endfunction

  function automatic int rx_trig_of(input logic [1:0] code, input int depth);
    int v;
    case (code)
      2'd0:    v = 1;
      2'd1:    v = 4;
      2'd2:    v = 8;
      default: v = 14;
    endcase
    return clamp_depth(v, depth);
  endfunction

  function automatic int tx_trig_of(input logic [1:0] code, input int depth);
    int v;
    case (code)
      2'd0:    v = 8;
      2'd1:    v = 4;
      2'd2:    v = 2;
      default: v = 1;
    endcase
    return clamp_depth(v, depth);
  endfunction
endpackage

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             fcr_wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       fcr_q,
  output logic             tx_clr,
  output logic             rx_clr,
  output logic [CNT_W-1:0] rx_thr,
  output logic [CNT_W-1:0] tx_thr
);
  localparam logic [7:0] FCR_KEEP = ~((8'h1 << FC_TRST) | (8'h1 << FC_RRST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fcr_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (fcr_wr)  fcr_q  <= wdata & FCR_KEEP;
    end
  end

  // clear pulses are live during the write cycle
  assign tx_clr = fcr_wr & wdata[FC_TRST];
  assign rx_clr = fcr_wr & wdata[FC_RRST];

  assign rx_thr = CNT_W'(rx_trig_of(fcr_q[7:6], DEPTH));
  assign tx_thr = CNT_W'(tx_trig_of(fcr_q[5:4], DEPTH));

  AST_FCR_RESET_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> (fcr_q[FC_TRST] == 1'b0 && fcr_q[FC_RRST] == 1'b0)); // R3
endmodule

// File: rtl/sio_frame_router.sv
module sio_frame_router #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             loop_en,
  input  logic             overrun,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             line_rx_avail,
  output logic             tx_pop,
  output logic             line_tx_valid,
  output logic             loop_push,
  output logic             line_rx_pop,
  output logic             rx_push
);
  logic rx_accept;

  assign rx_accept     = rx_en & ~overrun;
  assign tx_pop        = frame_tick & tx_en & (tx_count != '0);
  assign line_tx_valid = tx_pop & ~loop_en;
  assign loop_push     = tx_pop & loop_en & rx_accept;
  assign line_rx_pop   = frame_tick & ~loop_en & rx_accept & line_rx_avail;
  assign rx_push       = loop_push | line_rx_pop;

  AST_LOOP_NOT_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loop_push, line_tx_valid})); // R6
  AST_LOOP_BLOCKS_LINE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    loop_push |-> !line_rx_pop); // R6
  AST_OVERRUN_STOPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !rx_push); // R7
endmodule

// File: rtl/sio_status_flags.sv
module sio_status_flags
  import sio_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_wr,
  input  logic             ls_wr,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_thr,
  input  logic             tx_clr,
  input  logic             rx_clr,
  input  logic             frame_tick,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             err_frame,
  input  logic             err_parity,
  input  logic             brk_det,
  output logic [7:0]       st_q,
  output logic             ovr_q
);
  logic [7:0]       st_n;
  logic             ovr_n;
  logic             rcvd_q;
  logic [CNT_W-1:0] tx_left;
  logic [CNT_W:0]   rx_after;
  logic             rx_full;
  logic             dr_set;

  assign tx_left  = tx_count - CNT_W'(1);
  assign rx_after = {1'b0, rx_count} + (CNT_W + 1)'(1);
  assign rx_full  = (rx_count >= CNT_W'(DEPTH));
  assign dr_set   = frame_tick & ~rx_push & ~rcvd_q &
                    (rx_count != '0) & (rx_count < rx_thr);

  always_comb begin
    st_n  = st_q;
    ovr_n = ovr_q;
    if (st_wr) begin
      st_n = st_q & wdata;
      if (tx_count != '0)     st_n[ST_TEND] = 1'b1;
      if (tx_count <= tx_thr) st_n[ST_TDFE] = 1'b1;
      if (rx_count >= rx_thr) st_n[ST_RDF]  = 1'b1;
    end
    if (ls_wr && !wdata[0]) ovr_n = 1'b0;
    if (tx_pop) begin
      if (tx_left <= tx_thr)      st_n[ST_TDFE] = 1'b1;
      if (tx_count == CNT_W'(1))  st_n[ST_TEND] = 1'b1;
    end
    if (rx_push) begin
      if (rx_full) begin
        ovr_n = 1'b1;
      end else begin
        if (rx_after >= {1'b0, rx_thr}) st_n[ST_RDF] = 1'b1;
        if (err_frame) begin
          st_n[ST_ER]  = 1'b1;
          st_n[ST_FER] = 1'b1;
        end
        if (err_parity) begin
          st_n[ST_ER]  = 1'b1;
          st_n[ST_PER] = 1'b1;
        end
      end
    end
    if (dr_set)  st_n[ST_DR]  = 1'b1;
    if (brk_det) st_n[ST_BRK] = 1'b1;
    if (tx_clr) begin
      st_n[ST_TEND] = 1'b1;
      st_n[ST_TDFE] = 1'b1;
    end
    if (rx_clr) begin
      st_n[ST_DR]  = 1'b0;
      st_n[ST_RDF] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= STATUS_RESET;
      ovr_q  <= 1'b0;
      rcvd_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ovr_q <= ovr_n;
      if (frame_tick) rcvd_q <= rx_push;
    end
  end

  AST_TEND_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && tx_count != '0) |=> st_q[ST_TEND]); // R2
  AST_RDF_HELD_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && rx_count >= rx_thr && !rx_clr) |=> st_q[ST_RDF]); // R2
  AST_RX_CLEAR_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (!st_q[ST_DR] && !st_q[ST_RDF])); // R4
  AST_TX_CLEAR_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (st_q[ST_TEND] && st_q[ST_TDFE])); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(ls_wr && !wdata[0])) |=> ovr_q); // R11
  AST_FULL_PUSH_OVERRUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovr_q); // R8
  AST_BREAK_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> st_q[ST_BRK]); // R10
endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tie,
  input  logic       rie,
  input  logic       reie,
  input  logic [7:0] st_q,
  input  logic       ovr_q,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_err,
  output logic       irq_brk
);
  logic err_en;
  logic pend_tx, pend_rx, pend_err, pend_brk;

  assign err_en   = rie | reie;
  assign pend_tx  = st_q[ST_TDFE];
  assign pend_rx  = st_q[ST_DR] | st_q[ST_RDF];
  assign pend_err = st_q[ST_ER] | ovr_q;
  assign pend_brk = st_q[ST_BRK];

  assign irq_tx  = tie    & pend_tx;
  assign irq_rx  = rie    & pend_rx;
  assign irq_err = err_en & pend_err;
  assign irq_brk = err_en & pend_brk;

  AST_TX_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tie) |-> !irq_tx); // R12
  AST_RX_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rie) |-> !irq_rx); // R12
  AST_ERR_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (st_q[ST_ER] || ovr_q)); // R12
endmodule

// File: rtl/sio_status_block.sv
module sio_status_block
  import sio_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             frame_tick,
  input  logic             line_rx_avail,
  input  logic             rx_frame_err,
  input  logic             rx_parity_err,
  input  logic             brk_det,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       fcr_q,
  output logic [7:0]       status_q,
  output logic             overrun_q,
  output logic [CNT_W-1:0] rx_thr,
  output logic [CNT_W-1:0] tx_thr,
  output logic             tx_fifo_clr,
  output logic             rx_fifo_clr,
  output logic             tx_pop,
  output logic             line_tx_valid,
  output logic             loop_push,
  output logic             line_rx_pop,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             irq_brk
);
  logic ctrl_wr, fcr_wr, st_wr, ls_wr;
  logic rx_push;
  logic err_frame, err_parity;

  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign fcr_wr  = reg_wr && (reg_sel == SEL_FCR);
  assign st_wr   = reg_wr && (reg_sel == SEL_STAT);
  assign ls_wr   = reg_wr && (reg_sel == SEL_LINE);

  assign err_frame  = line_rx_pop & rx_frame_err;
  assign err_parity = line_rx_pop & rx_parity_err;

  sio_ctrl_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .fcr_wr (fcr_wr),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .fcr_q  (fcr_q),
    .tx_clr (tx_fifo_clr),
    .rx_clr (rx_fifo_clr),
    .rx_thr (rx_thr),
    .tx_thr (tx_thr)
  );

  sio_frame_router #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_route (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_tick   (frame_tick),
    .tx_en        (ctrl_q[CT_TE]),
    .rx_en        (ctrl_q[CT_RE]),
    .loop_en      (fcr_q[FC_LOOP]),
    .overrun      (overrun_q),
    .tx_count     (tx_count),
    .line_rx_avail(line_rx_avail),
    .tx_pop       (tx_pop),
    .line_tx_valid(line_tx_valid),
    .loop_push    (loop_push),
    .line_rx_pop  (line_rx_pop),
    .rx_push      (rx_push)
  );

  sio_status_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_wr     (st_wr),
    .ls_wr     (ls_wr),
    .wdata     (reg_wdata),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .tx_thr    (tx_thr),
    .rx_thr    (rx_thr),
    .tx_clr    (tx_fifo_clr),
    .rx_clr    (rx_fifo_clr),
    .frame_tick(frame_tick),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .err_frame (err_frame),
    .err_parity(err_parity),
    .brk_det   (brk_det),
    .st_q      (status_q),
    .ovr_q     (overrun_q)
  );

  sio_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tie    (ctrl_q[CT_TIE]),
    .rie    (ctrl_q[CT_RIE]),
    .reie   (ctrl_q[CT_REIE]),
    .st_q   (status_q),
    .ovr_q  (overrun_q),
    .irq_tx (irq_tx),
    .irq_rx (irq_rx),
    .irq_err(irq_err),
    .irq_brk(irq_brk)
  );

  AST_BREAK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && (ctrl_q[CT_RIE] || ctrl_q[CT_REIE]) && !ctrl_wr) |=> irq_brk); // R10
  AST_LOOP_PUSH_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_push |-> (tx_pop && fcr_q[FC_LOOP])); // R6
endmodule

// File: tb/test_sio_status_block.sv
module test_sio_status_block;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [CNT_W-1:0] tx_count = '0, rx_count = '0;
  logic frame_tick = 1'b0, line_rx_avail = 1'b0;
  logic rx_frame_err = 1'b0, rx_parity_err = 1'b0, brk_det = 1'b0;
  logic [7:0] ctrl_q, fcr_q, status_q;
  logic overrun_q;
  logic [CNT_W-1:0] rx_thr, tx_thr;
  logic tx_fifo_clr, rx_fifo_clr, tx_pop, line_tx_valid, loop_push, line_rx_pop;
  logic irq_tx, irq_rx, irq_err, irq_brk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sio_status_block #(.DEPTH(DEPTH)) i_sio_status_block (.*);

  // {tx_count, rx_count, written value, expected status}; thresholds tx 8, rx 1
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd0, 8'h00, 8'h20},
    {8'd3, 8'd0, 8'h00, 8'h60},
    {8'd9, 8'd0, 8'h00, 8'h40},
    {8'd9, 8'd2, 8'h00, 8'h42},
    {8'd0, 8'd0, 8'hFF, 8'h60},
    {8'd9, 8'd0, 8'h40, 8'h40},
    {8'd9, 8'd0, 8'h20, 8'h60},
    {8'd8, 8'd5, 8'h00, 8'h62}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick_on();
    frame_tick = 1'b1;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    frame_tick = 1'b0;
    brk_det = 1'b0;
  endtask

  initial begin
    int rxv[4] = '{1, 4, 8, 14};
    int txv[4] = '{8, 4, 2, 1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", status_q, 8'h60);
    chk("R1 ctrl/fcr/ovr", {ctrl_q, fcr_q, 7'd0, overrun_q}, '0);
    chk("R1 irqs", {irq_tx, irq_rx, irq_err, irq_brk}, '0);

    // R3 threshold decode and readback
    wr(2'd1, 8'h0F);
    chk("R3 fcr readback", fcr_q, 8'h09);
    for (int c = 0; c < 4; c++) begin
      wr(2'd1, {c[1:0], c[1:0], 4'h0});
      chk("R3 rx_thr", rx_thr, rxv[c]);
      chk("R3 tx_thr", tx_thr, txv[c]);
    end
    wr(2'd1, 8'h00);

    // R2 vector table: reset both fifos, then one status write
    for (int i = 0; i < 8; i++) begin
      tx_count = VEC[i][28:24];
      rx_count = VEC[i][20:16];
      wr(2'd1, 8'h06);
      wr(2'd2, VEC[i][15:8]);
      chk("R2 status write", status_q, VEC[i][7:0]);
    end

    // R4 fifo clear pulses
    tx_count = 9; rx_count = 0;
    wr(2'd2, 8'h00);
    chk("R4 pre", status_q, 8'h40);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h04; #1;
    chk("R4 tx clr pulse", {tx_fifo_clr, rx_fifo_clr}, 2'b10);
    @(negedge clk); reg_wr = 1'b0;
    chk("R4 tx clr flags", status_q, 8'h60);
    rx_count = 2;
    wr(2'd2, 8'h00);
    chk("R4 rdf held", status_q, 8'h42);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h02; #1;
    chk("R4 rx clr pulse", {tx_fifo_clr, rx_fifo_clr}, 2'b01);
    @(negedge clk); reg_wr = 1'b0;
    chk("R4 rx clr flags", status_q, 8'h40);

    // R5 transmit pops
    wr(2'd0, 8'h20);
    tick_on();
    chk("R5 pop", tx_pop, 1'b1);
    chk("R6 to line", {line_tx_valid, loop_push}, 2'b10);
    step();
    chk("R5 tdfe on pop", status_q, 8'h60);
    wr(2'd0, 8'hA0);
    chk("R12 irq_tx on", irq_tx, 1'b1);
    wr(2'd0, 8'h20);
    chk("R12 irq_tx off", irq_tx, 1'b0);
    rx_count = 0; tx_count = 0;
    wr(2'd2, 8'h00);
    chk("R2 tend clears when empty", status_q, 8'h20);
    tick_on();
    chk("R5 no pop when empty", tx_pop, 1'b0);
    step();
    tx_count = 1;
    tick_on(); step();
    chk("R5 tend on last pop", status_q, 8'h60);

    // R6 R7 loopback routing
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h30);
    tx_count = 3; line_rx_avail = 1'b1;
    tick_on();
    chk("R6 loop route", {tx_pop, loop_push, line_tx_valid, line_rx_pop}, 4'b1100);
    step();
    chk("R8 rdf on push", status_q, 8'h62);
    wr(2'd0, 8'h20);
    tick_on();
    chk("R7 no accept without RE", {tx_pop, loop_push}, 2'b10);
    step();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h30);
    tick_on();
    chk("R6 line route", {line_tx_valid, loop_push, line_rx_pop}, 3'b101);
    step();

    // R8 overrun on full, R11 sticky
    rx_count = DEPTH[CNT_W-1:0]; rx_frame_err = 1'b1;
    tick_on(); step();
    chk("R8 overrun set", overrun_q, 1'b1);
    chk("R8 dropped byte leaves flags", status_q, 8'h62);
    tick_on();
    chk("R7 overrun blocks rx", line_rx_pop, 1'b0);
    step();
    wr(2'd0, 8'h38);
    chk("R12 irq_err overrun", irq_err, 1'b1);
    wr(2'd3, 8'h01);
    chk("R11 write 1 keeps", overrun_q, 1'b1);
    wr(2'd3, 8'h00);
    chk("R11 cleared", {overrun_q, irq_err}, 2'b00);

    // R8 framing error on accepted byte
    rx_count = 5;
    tick_on(); step();
    rx_frame_err = 1'b0; line_rx_avail = 1'b0;
    chk("R8 framing err", status_q, 8'hEA);
    chk("R12 irq_err on ER", irq_err, 1'b1);
    wr(2'd2, 8'h7F);
    chk("R2 er cleared", status_q, 8'h6A);
    chk("R12 irq_err drop", irq_err, 1'b0);

    // R9 data ready after two quiet ticks
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'h00);
    chk("R2 below rx thr", status_q, 8'h60);
    tick_on(); step();
    chk("R9 not after push tick", status_q, 8'h60);
    tick_on(); step();
    chk("R9 dr set", status_q, 8'h61);
    wr(2'd0, 8'h78);
    chk("R12 irq_rx on", irq_rx, 1'b1);
    wr(2'd0, 8'h38);
    chk("R12 irq_rx off", irq_rx, 1'b0);

    // R10 break
    brk_det = 1'b1;
    step();
    chk("R10 brk flag", status_q, 8'h71);
    chk("R12 irq_brk reie", irq_brk, 1'b1);
    wr(2'd0, 8'h30);
    chk("R12 irq_brk disabled", irq_brk, 1'b0);
    wr(2'd0, 8'h40);
    chk("R12 irq_brk rie", irq_brk, 1'b1);
    wr(2'd2, 8'hEF);
    chk("R10 brk cleared", {status_q, irq_brk}, {8'h61, 1'b0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule